// File: doc/BRIEF.md
# Read/Write Address Command Arbiter

This block sits in front of a memory controller that has a single command port. It takes two independent address request channels, one for reads and one for writes. Each channel carries an address, a burst length and a transaction ID under a valid/ready handshake. In every cycle the block picks at most one of the two channels and forwards its fields to the command port, together with a flag that marks the command as a write or a read.

A 2-bit static mode input selects one of four grant policies:

- a fixed time-slot rotation that ignores requests;
- a request-aware alternation;
- strict read preference;
- read preference with a cap on how many reads may pass a waiting write.

The grant is combinational, so a command is forwarded in the same cycle its request is presented. The only state is the slot pointer, the starvation counter and the registered mode.

Top module: `addr_cmd_arbiter`

## Requirements
- R1: In any cycle at most one of `rd_ready_o` and `wr_ready_o` is high. A channel's ready is high only when that channel holds the grant and `cmd_ready_i` is high.
- R2: `cmd_valid_o` equals the valid of the granted channel. While `cmd_valid_o` is high, `cmd_write_o` is 1 for a write and 0 for a read, and `cmd_addr_o`, `cmd_len_o` and `cmd_id_o` equal the granted channel's fields.
- R3: In mode 0 (time-slot) the slot owner alternates read, write, read, ... on every clock edge, whatever the requests. The owner always holds the grant. When the owner has no request, the slot passes with `cmd_valid_o` low.
- R4: In mode 1 (alternation) the slot pointer alternates as in mode 0. The owner is granted if it is requesting. Otherwise the other channel is granted if it is requesting.
- R5: In mode 2 (read preference) a pending read is always granted. A write is granted only in cycles with `rd_valid_i` low.
- R6: In mode 3 (capped read preference) a pending write is granted when `rd_valid_i` is low or when the starvation count has reached `STARVE_LIMIT`; otherwise a pending read is granted. The count:
  - rises by one, saturating at `STARVE_LIMIT`, on each completed read while `wr_valid_i` is high;
  - clears on each completed write;
  - is zero after reset;
  - is kept in all modes.
- R7: The mode is loaded from `mode_i` only in cycles where both `rd_valid_i` and `wr_valid_i` are low, or while `rst_n` is low. A change of `mode_i` while a request is pending has no effect on the grants.
- R8: With `cmd_ready_i` low, no handshake completes: both readies are low and the starvation count does not change.
- R9: After reset the slot pointer is on the read channel. The first cycle with `rst_n` high belongs to read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Policy select: 0 time-slot, 1 alternation, 2 read preference, 3 capped read preference |
| rd_valid_i | input | 1 | Read request valid |
| rd_addr_i | input | ADDR_W | Read address |
| rd_len_i | input | LEN_W | Read burst length |
| rd_id_i | input | ID_W | Read transaction ID |
| rd_ready_o | output | 1 | Read request accepted |
| wr_valid_i | input | 1 | Write request valid |
| wr_addr_i | input | ADDR_W | Write address |
| wr_len_i | input | LEN_W | Write burst length |
| wr_id_i | input | ID_W | Write transaction ID |
| wr_ready_o | output | 1 | Write request accepted |
| cmd_valid_o | output | 1 | Command valid |
| cmd_write_o | output | 1 | 1 = write command, 0 = read command |
| cmd_addr_o | output | ADDR_W | Command address |
| cmd_len_o | output | LEN_W | Command burst length |
| cmd_id_o | output | ID_W | Command ID |
| cmd_ready_i | input | 1 | Controller accepts command |

## Verification
All command outputs and both readies follow the inputs in the same cycle, with no register on the way. Slot pointer, starvation count and mode each take effect from the clock edge after the cycle that changes them. The bench drives each cycle's inputs on the falling edge and pushes the expected outputs, computed from its own slot, count and mode model, into a queue. A monitor pops and compares them 2 ns later, still before the next rising edge. The model's state is advanced only after that rising edge, using the handshakes it predicted. A count, slot or mode effect is therefore always checked one cycle after its cause.

// File: rtl/arb_pkg.sv
// Shared definitions for the address command arbiter.
// Assumes: the 2-bit mode encoding is fixed and seen by software.
package arb_pkg;
    typedef enum logic [1:0] {
        ARB_SLOT     = 2'd0,
        ARB_ALT      = 2'd1,
        ARB_RDFIRST  = 2'd2,
        ARB_RDCAPPED = 2'd3
    } arb_mode_e;
endpackage

// File: rtl/arb_starve_ctr.sv
// Counts reads completed while a write waits; saturates at LIMIT.
// Assumes: LIMIT >= 1; handshakes are mutually exclusive.
module arb_starve_ctr #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_done,
    input  logic wr_done,
    input  logic wr_waiting,
    output logic starved
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Track consecutive read wins over a waiting write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_done) begin
            cnt_q <= '0;
        end else if (rd_done && wr_waiting && (cnt_q < CW'(LIMIT))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign starved = (cnt_q >= CW'(LIMIT));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT));
    // R6
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> (cnt_q == '0));
    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_done && !wr_done) |=> $stable(cnt_q));
endmodule

// File: rtl/arb_policy.sv
// Grant decision for the four policies, plus the alternating slot pointer.
// Assumes: mode is stable while requests are pending (held by the top).
module arb_policy
    import arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  arb_mode_e mode,
    input  logic      rd_req,
    input  logic      wr_req,
    input  logic      starved,
    output logic      grant_wr
);
    logic slot_wr_q;

    // Slot pointer flips on every edge out of reset; read owns first slot.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_wr_q <= 1'b0;
        else        slot_wr_q <= ~slot_wr_q;
    end

    // Select which channel owns the command port this cycle.
    always_comb begin
        unique case (mode)
            ARB_SLOT:     grant_wr = slot_wr_q;
            ARB_ALT:      grant_wr = slot_wr_q ? (wr_req || !rd_req)
                                               : (wr_req && !rd_req);
            ARB_RDFIRST:  grant_wr = wr_req && !rd_req;
            ARB_RDCAPPED: grant_wr = wr_req && (!rd_req || starved);
            default:      grant_wr = 1'b0;
        endcase
    end

    // R3
    slot_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ARB_SLOT && grant_wr) |=> (mode != ARB_SLOT || !grant_wr));
    // R5
    rd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ARB_RDFIRST && rd_req) |-> !grant_wr);
    // R4
    alt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ARB_ALT && wr_req && !rd_req) |-> grant_wr);
endmodule

// File: rtl/arb_cmd_mux.sv
// Steers the granted channel's fields onto the command port.
// Assumes: sel_wr is a settled grant from the policy logic.
module arb_cmd_mux #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int ID_W   = 4
) (
    input  logic              sel_wr,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [LEN_W-1:0]  rd_len,
    input  logic [ID_W-1:0]   rd_id,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [ID_W-1:0]   wr_id,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic [ID_W-1:0]   cmd_id
);
    // Two-way field select driven by the grant.
    always_comb begin
        cmd_write = sel_wr;
        cmd_valid = sel_wr ? wr_valid : rd_valid;
        cmd_addr  = sel_wr ? wr_addr  : rd_addr;
        cmd_len   = sel_wr ? wr_len   : rd_len;
        cmd_id    = sel_wr ? wr_id    : rd_id;
    end
endmodule

// File: rtl/addr_cmd_arbiter.sv
// Merges read and write address requests onto one command port.
// Assumes: downstream ready may toggle freely; mode_i is quasi-static.
module addr_cmd_arbiter
    import arb_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int LEN_W        = 8,
    parameter int ID_W         = 4,
    parameter int STARVE_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              rd_valid_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [LEN_W-1:0]  rd_len_i,
    input  logic [ID_W-1:0]   rd_id_i,
    output logic              rd_ready_o,
    input  logic              wr_valid_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [LEN_W-1:0]  wr_len_i,
    input  logic [ID_W-1:0]   wr_id_i,
    output logic              wr_ready_o,
    output logic              cmd_valid_o,
    output logic              cmd_write_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [LEN_W-1:0]  cmd_len_o,
    output logic [ID_W-1:0]   cmd_id_o,
    input  logic              cmd_ready_i
);
    arb_mode_e mode_q;
    logic      grant_wr;
    logic      starved;
    logic      idle;

    assign idle = !rd_valid_i && !wr_valid_i;

    // Capture the policy only when no request is outstanding or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n || idle) mode_q <= arb_mode_e'(mode_i);
    end

    arb_policy u_policy (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .rd_req   (rd_valid_i),
        .wr_req   (wr_valid_i),
        .starved  (starved),
        .grant_wr (grant_wr)
    );

    arb_cmd_mux #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .ID_W   (ID_W)
    ) u_mux (
        .sel_wr    (grant_wr),
        .rd_valid  (rd_valid_i),
        .rd_addr   (rd_addr_i),
        .rd_len    (rd_len_i),
        .rd_id     (rd_id_i),
        .wr_valid  (wr_valid_i),
        .wr_addr   (wr_addr_i),
        .wr_len    (wr_len_i),
        .wr_id     (wr_id_i),
        .cmd_valid (cmd_valid_o),
        .cmd_write (cmd_write_o),
        .cmd_addr  (cmd_addr_o),
        .cmd_len   (cmd_len_o),
        .cmd_id    (cmd_id_o)
    );

    // Acceptance back to the granted source only.
    assign rd_ready_o = !grant_wr && cmd_ready_i;
    assign wr_ready_o =  grant_wr && cmd_ready_i;

    arb_starve_ctr #(
        .LIMIT (STARVE_LIMIT)
    ) u_starve (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_done    (rd_ready_o && rd_valid_i),
        .wr_done    (wr_ready_o && wr_valid_i),
        .wr_waiting (wr_valid_i),
        .starved    (starved)
    );

    // R1
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ready_o && wr_ready_o));
    // R2
    wr_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_write_o) |-> (cmd_addr_o == wr_addr_i && cmd_id_o == wr_id_i));
    // R2
    rd_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_write_o) |-> (cmd_addr_o == rd_addr_i && cmd_len_o == rd_len_i));
    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(mode_q));
endmodule

// File: tb/test_addr_cmd_arbiter.sv
module test_addr_cmd_arbiter;
    localparam int AW  = 32;
    localparam int LW  = 8;
    localparam int IW  = 4;
    localparam int LIM = 8;
    localparam int VW  = 4 + AW + LW + IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = 2'd0;
    logic          rd_valid_i = 1'b0, wr_valid_i = 1'b0, cmd_ready_i = 1'b0;
    logic [AW-1:0] rd_addr_i = '0, wr_addr_i = '0;
    logic [LW-1:0] rd_len_i = '0, wr_len_i = '0;
    logic [IW-1:0] rd_id_i = '0, wr_id_i = '0;
    logic          rd_ready_o, wr_ready_o, cmd_valid_o, cmd_write_o;
    logic [AW-1:0] cmd_addr_o;
    logic [LW-1:0] cmd_len_o;
    logic [IW-1:0] cmd_id_o;

    always #2.5 clk = ~clk;

    addr_cmd_arbiter #(.ADDR_W(AW), .LEN_W(LW), .ID_W(IW), .STARVE_LIMIT(LIM)) i_addr_cmd_arbiter (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .rd_valid_i(rd_valid_i), .rd_addr_i(rd_addr_i), .rd_len_i(rd_len_i),
        .rd_id_i(rd_id_i), .rd_ready_o(rd_ready_o),
        .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i), .wr_len_i(wr_len_i),
        .wr_id_i(wr_id_i), .wr_ready_o(wr_ready_o),
        .cmd_valid_o(cmd_valid_o), .cmd_write_o(cmd_write_o), .cmd_addr_o(cmd_addr_o),
        .cmd_len_o(cmd_len_o), .cmd_id_o(cmd_id_o), .cmd_ready_i(cmd_ready_i)
    );

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 0;

    // Reference model state
    logic   m_slot_wr;
    int     m_cnt  = 0;
    int     m_mode = 0;

    string           q_tag[$];
    logic [VW-1:0]   q_exp[$];

    always @(posedge clk) begin
        if (!rst_n) m_slot_wr <= 1'b0;
        else        m_slot_wr <= ~m_slot_wr;
    end

    function automatic logic exp_grant_wr(input int md, input logic slot,
                                          input logic rv, input logic wv, input int cnt);
        case (md)
            0:       return slot;
            1:       return slot ? (wv || !rv) : (wv && !rv);
            2:       return wv && !rv;
            default: return wv && (!rv || cnt >= LIM);
        endcase
    endfunction

    function automatic logic [VW-1:0] pack(input logic v, input logic w, input logic rr,
                                           input logic wr, input logic [AW-1:0] a,
                                           input logic [LW-1:0] l, input logic [IW-1:0] id);
        if (v) return {v, w, rr, wr, a, l, id};
        return {v, 1'b0, rr, wr, {AW{1'b0}}, {LW{1'b0}}, {IW{1'b0}}};
    endfunction

    task automatic do_reset(input logic [1:0] md);
        @(negedge clk);
        rst_n = 1'b0; mode_i = md;
        rd_valid_i = 1'b0; wr_valid_i = 1'b0; cmd_ready_i = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_mode = int'(md);
        m_cnt  = 0;
    endtask

    task automatic step(input string tag, input logic rv, input logic wv,
                        input logic rdy, input logic [1:0] md);
        logic gw, ev, rr, wr;
        @(negedge clk);
        mode_i      = md;
        rd_valid_i  = rv;  wr_valid_i = wv;  cmd_ready_i = rdy;
        rd_addr_i   = 32'h1000_0000 + AW'(cyc);
        wr_addr_i   = 32'h8000_0000 + AW'(cyc * 3);
        rd_len_i    = LW'(cyc + 1);
        wr_len_i    = LW'(cyc + 7);
        rd_id_i     = IW'(cyc);
        wr_id_i     = IW'(cyc + 5);
        gw = exp_grant_wr(m_mode, m_slot_wr, rv, wv, m_cnt);
        ev = gw ? wv : rv;
        rr = !gw && rdy;
        wr =  gw && rdy;
        q_tag.push_back(tag);
        q_exp.push_back(pack(ev, gw, rr, wr, gw ? wr_addr_i : rd_addr_i,
                             gw ? wr_len_i : rd_len_i, gw ? wr_id_i : rd_id_i));
        @(posedge clk);
        if (wr && wv)            m_cnt = 0;
        else if (rr && rv && wv) m_cnt = (m_cnt < LIM) ? m_cnt + 1 : m_cnt;
        if (!rv && !wv)          m_mode = int'(md);
    endtask

    // Monitor: compare design outputs against queued expectations.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q_exp.size() > 0) begin
                string tg;
                logic [VW-1:0] e, a;
                tg = q_tag.pop_front();
                e  = q_exp.pop_front();
                a  = pack(cmd_valid_o, cmd_write_o, rd_ready_o, wr_ready_o,
                          cmd_addr_o, cmd_len_o, cmd_id_o);
                tests++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h (v,w,rrdy,wrdy,addr,len,id)", tg, a, e);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset(2'd0);
        // R1 reset/idle: nothing offered, nothing granted
        step("R1 idle", 0, 0, 1, 2'd0);
        // R3 / R9: time-slot, both requesting -> strict alternation
        for (int i = 0; i < 4; i++) step("R3 slot both", 1, 1, 1, 2'd0);
        // R3: only write requesting -> read slots wasted
        for (int i = 0; i < 4; i++) step("R3 slot wr only", 0, 1, 1, 2'd0);
        // R8: downstream stalled
        for (int i = 0; i < 2; i++) step("R8 stall", 1, 1, 0, 2'd0);
        // R7: switch to alternation while idle
        step("R7 load alt", 0, 0, 1, 2'd1);
        for (int i = 0; i < 3; i++) step("R4 alt wr only", 0, 1, 1, 2'd1);
        for (int i = 0; i < 4; i++) step("R4 alt both", 1, 1, 1, 2'd1);
        for (int i = 0; i < 2; i++) step("R4 alt rd only", 1, 0, 1, 2'd1);
        // R5: read preference
        step("R7 load rdfirst", 0, 0, 1, 2'd2);
        for (int i = 0; i < 3; i++) step("R5 rdfirst both", 1, 1, 1, 2'd2);
        for (int i = 0; i < 2; i++) step("R5 rdfirst wr only", 0, 1, 1, 2'd2);
        // R7: mode change while busy ignored
        for (int i = 0; i < 3; i++) step("R7 busy mode change", 1, 1, 1, 2'd0);
        // R6: capped read preference
        step("R7 load capped", 0, 0, 1, 2'd3);
        for (int i = 0; i < 5; i++) step("R6 capped both", 1, 1, 1, 2'd3);
        for (int i = 0; i < 2; i++) step("R8 capped stall", 1, 1, 0, 2'd3);
        for (int i = 0; i < 12; i++) step("R6 capped both", 1, 1, 1, 2'd3);
        step("R6 capped rd only", 1, 0, 1, 2'd3);
        step("R6 capped wr only", 0, 1, 1, 2'd3);
        // R7 / R9: mode taken during reset; slot restarts on read
        do_reset(2'd1);
        for (int i = 0; i < 4; i++) step("R9 alt after reset", 1, 1, 1, 2'd1);
        // R2: field routing under mixed traffic in time-slot mode
        do_reset(2'd0);
        for (int i = 0; i < 3; i++) step("R2 fields", 1, 1, 1, 2'd0);
        step("R2 fields rd only", 1, 0, 1, 2'd0);
        step("R2 fields rd only", 1, 0, 1, 2'd0);
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule